// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a 32-bit down-counter that a processor-local interrupt unit uses for its timer interrupt. Software programs a control word (interrupt vector, mask, periodic or one-shot operation), a divide setting and an initial count. Writing the initial count loads the counter and starts it. The counter then steps down once per prescaled tick. When a tick arrives while the count is already zero, the timer expires. It emits a one-cycle strobe together with the vector, unless it is masked.

In one-shot operation the counter comes to rest at zero after one expiry and stays there until software writes a new initial count. In periodic operation it reloads the initial count at each expiry, so the strobe repeats every initial count plus one ticks. The live count value is always available on an output port. Deciding which of several pending interrupts is served first is left to the logic that receives the strobe.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the count output is 0 and no strobe is present. The control word is masked, not periodic, with vector 0. The divide code is 0, which gives a tick every 2 clocks.
- R2: A divide write keeps only data bits 3, 1 and 0. It forms the code {bit3, bit1, bit0} and the shift (code+1) mod 8, so a tick comes every 2^shift clocks and code 7 gives one tick per clock. All other data bits are ignored.
- R3: The first tick comes 2^shift clock edges after the edge that accepted the initial-count write, and further ticks follow every 2^shift edges. Each tick lowers a nonzero count by exactly 1.
- R4: In one-shot operation (control bit 17 = 0) the count equals the initial count minus the elapsed ticks and saturates at 0. The strobe fires once, on tick number initial+1. The count then stays 0 with no further strobe until the next initial-count write.
- R5: In periodic operation (control bit 17 = 1) the count is reloaded with the initial count on the expiring tick. The strobe fires on ticks initial+1, 2(initial+1), and so on.
- R6: In periodic operation with an initial count of 0 the strobe never fires and the count stays 0.
- R7: While control bit 16 (mask) is 1, no strobe is issued. The count keeps running.
- R8: The strobe lasts one clock. The vector output then holds control bits 7:0 as they stood at the expiring tick.
- R9: An initial-count write restarts both the prescaler and the counter at the same edge. A control-word write does not disturb either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 32 | Control word: bit 17 periodic, bit 16 mask, bits 7:0 vector |
| div_we | input | 1 | Divide setting write enable |
| div_wdata | input | 32 | Divide setting; bits 3, 1, 0 used |
| init_we | input | 1 | Initial count write enable; starts the timer |
| init_wdata | input | CNT_W | Initial count |
| cur_count | output | CNT_W | Live count value |
| expire_o | output | 1 | One-cycle expiry strobe |
| expire_vec | output | 8 | Vector sent with the strobe |

## Verification
The assertions assume that reset is applied before any write. They also assume that no initial-count write falls in the cycle they watch, since such a write may load an arbitrary value. A change of divide setting while the counter runs can stretch the current prescale window, so the stimulus changes the divide setting only before an initial-count write. The stimulus issues writes one at a time on the falling edge and holds each enable for exactly one rising edge.

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [31:0]      ctrl_wdata,
  input  logic             div_we,
  input  logic [31:0]      div_wdata,
  input  logic             init_we,
  input  logic [CNT_W-1:0] init_wdata,
  output logic [CNT_W-1:0] cur_count,
  output logic             expire_o,
  output logic [7:0]       expire_vec
);
  localparam int SH_W  = 3;
  localparam int PRE_W = (1 << SH_W) - 1;
  localparam int PERIODIC_BIT = 17;
  localparam int MASK_BIT     = 16;

  logic [SH_W-1:0]  div_code_q;
  logic [PRE_W-1:0] pre_q;
  logic             periodic_q, mask_q;
  logic [7:0]       vec_q;
  logic [CNT_W-1:0] init_q, cnt_q;
  logic             armed_q, expire_q;
  logic [7:0]       exp_vec_q;

  wire [SH_W-1:0]  shift   = div_code_q + 1'b1;
  wire [PRE_W-1:0] pre_lim = (PRE_W'(1) << shift) - 1'b1;
  wire             tick    = pre_q >= pre_lim;
  wire             at_zero = cnt_q == '0;
  wire             fire    = tick && armed_q && at_zero && (!periodic_q || init_q != '0);

  assign cur_count  = cnt_q;
  assign expire_o   = expire_q;
  assign expire_vec = exp_vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodic_q <= 1'b0;
      mask_q     <= 1'b1;
      vec_q      <= '0;
    end else if (ctrl_we) begin
      periodic_q <= ctrl_wdata[PERIODIC_BIT];
      mask_q     <= ctrl_wdata[MASK_BIT];
      vec_q      <= ctrl_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_code_q <= '0;
    else if (div_we) div_code_q <= {div_wdata[3], div_wdata[1], div_wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      init_q    <= '0;
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      expire_q  <= 1'b0;
      exp_vec_q <= '0;
    end else if (init_we) begin
      pre_q    <= '0;
      init_q   <= init_wdata;
      cnt_q    <= init_wdata;
      armed_q  <= 1'b1;
      expire_q <= 1'b0;
    end else begin
      expire_q <= fire && !mask_q;
      if (fire) exp_vec_q <= vec_q;
      if (tick) begin
        pre_q <= '0;
        if (armed_q) begin
          if (!at_zero)        cnt_q   <= cnt_q - 1'b1;
          else if (periodic_q) cnt_q   <= init_q;
          else                 armed_q <= 1'b0;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_we && !periodic_q && cnt_q == '0) |=> cnt_q == '0);

  p_fire_from_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> $past(cnt_q) == '0);

  p_zero_period_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_q && init_q == '0 && !init_we) |=> !expire_q);

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> !expire_q);

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);
endmodule

// File: tb/irq_countdown_timer_tb.sv
module irq_countdown_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, div_we = 1'b0, init_we = 1'b0;
  logic [31:0] ctrl_wdata = '0, div_wdata = '0, init_wdata = '0;
  logic [31:0] cur_count;
  logic        expire_o;
  logic [7:0]  expire_vec;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  irq_countdown_timer u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .init_we(init_we), .init_wdata(init_wdata),
    .cur_count(cur_count), .expire_o(expire_o), .expire_vec(expire_vec)
  );

  localparam int NV = 8;
  localparam int unsigned T_DIV  [NV] = '{32'h0, 32'hB, 32'h3, 32'h8, 32'hF4, 32'h9, 32'hA, 32'h2};
  localparam int unsigned T_PER  [NV] = '{2, 1, 16, 32, 2, 64, 128, 8};
  localparam int unsigned T_INIT [NV] = '{3, 5, 2, 1, 4, 0, 0, 3};
  localparam int unsigned T_VEC  [NV] = '{8'h21, 8'h30, 8'h41, 8'h52, 8'h63, 8'h74, 8'h85, 8'hF6};

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  task automatic wr_ctrl(input logic [31:0] d);
    ctrl_wdata = d; ctrl_we = 1'b1;
    @(posedge clk); @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_div(input logic [31:0] d);
    div_wdata = d; div_we = 1'b1;
    @(posedge clk); @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic wr_init(input logic [31:0] d);
    init_wdata = d; init_we = 1'b1;
    @(posedge clk); @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic wait_fire(input int n0, input int limit, output int n, output int v);
    n = n0; v = -1;
    while (n < limit) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (expire_o) begin v = expire_vec; return; end
    end
    n = -1;
  endtask

  task automatic quiet(input int len, output int strobes);
    strobes = 0;
    repeat (len) begin
      @(posedge clk); @(negedge clk);
      if (expire_o) strobes++;
    end
  endtask

  initial begin
    int n, v, s, bad;
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cur_count == 0, "R1 count at reset", cur_count, 0);
    check(expire_o == 0, "R1 strobe at reset", expire_o, 0);

    // R1/R3/R7 default divide (2 clocks) and default mask: counts but no strobe
    wr_init(32'd2);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(cur_count == 1, "R1 default divide by 2, count after 2 edges", cur_count, 1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(cur_count == 0, "R3 count after 4 edges", cur_count, 0);
    quiet(20, s);
    check(s == 0, "R1 masked after reset, no strobe", s, 0);

    // R2/R3/R4/R8 table of divide settings and one-shot expiry times
    for (int i = 0; i < NV; i++) begin
      int exp_n, t, e;
      wr_div(T_DIV[i]);
      wr_ctrl(T_VEC[i]);
      wr_init(T_INIT[i]);
      exp_n = T_PER[i] * (T_INIT[i] + 1);
      n = 0; bad = 0; v = -1;
      while (n < exp_n + 4) begin
        @(posedge clk); n++;
        @(negedge clk);
        t = n / T_PER[i];
        e = (t >= T_INIT[i]) ? 0 : T_INIT[i] - t;
        if (cur_count != e) bad++;
        if (expire_o) begin v = expire_vec; break; end
      end
      check(bad == 0, "R3 count trace", bad, 0);
      check(n == exp_n, "R2 expiry edge for divide setting", n, exp_n);
      check(v == T_VEC[i], "R8 vector on strobe", v, T_VEC[i]);
      @(posedge clk); @(negedge clk);
      check(expire_o == 0, "R8 strobe lasts one clock", expire_o, 0);
    end

    // R4 after one-shot expiry: count stays 0, no further strobe
    quiet(300, s);
    check(s == 0, "R4 no second one-shot strobe", s, 0);
    check(cur_count == 0, "R4 count rests at 0", cur_count, 0);

    // R5 periodic, divide by 1, initial 3: strobes at edges 4, 8, 12
    wr_div(32'hB);
    wr_ctrl(32'h0002_0055);
    wr_init(32'd3);
    bad = 0; v = 0;
    for (int k = 1; k <= 13; k++) begin
      @(posedge clk); @(negedge clk);
      if (expire_o != (k % 4 == 0)) bad++;
      if (expire_o && expire_vec != 8'h55) bad++;
      if (k == 4) v = cur_count;
    end
    check(bad == 0, "R5 periodic strobe pattern", bad, 0);
    check(v == 3, "R5 reload on expiry", v, 3);

    // R7 mask while periodic: count runs, no strobe
    wr_ctrl(32'h0003_0055);
    c0 = cur_count;
    @(posedge clk); @(negedge clk);
    check(cur_count != c0, "R7 count runs while masked", cur_count, c0);
    quiet(20, s);
    check(s == 0, "R7 masked periodic, no strobe", s, 0);

    // R6 periodic with initial 0
    wr_ctrl(32'h0002_0066);
    wr_init(32'd0);
    bad = 0;
    s = 0;
    repeat (50) begin
      @(posedge clk); @(negedge clk);
      if (expire_o) s++;
      if (cur_count != 0) bad++;
    end
    check(s == 0, "R6 zero periodic never fires", s, 0);
    check(bad == 0, "R6 count stays 0", bad, 0);

    // R9 rewriting initial count restarts
    wr_div(32'h0);
    wr_ctrl(32'h0000_0011);
    wr_init(32'd5);
    repeat (7) begin @(posedge clk); @(negedge clk); end
    wr_init(32'd5);
    wait_fire(0, 40, n, v);
    check(n == 12, "R9 init rewrite restarts count", n, 12);

    // R9/R8 control write mid-count keeps timing, new vector used
    wr_init(32'd4);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    wr_ctrl(32'h0000_0099);
    wait_fire(4, 40, n, v);
    check(n == 10, "R9 control write does not restart", n, 10);
    check(v == 8'h99, "R8 vector taken at expiry", v, 8'h99);

    finish_up();
  end
endmodule